// File: doc/BRIEF.md
# Scatter-Gather Storage DMA Engine

This block moves data between system memory and the data port of a storage device on behalf of the host. Software places a chain of two-word descriptors in memory, writes the address of the first one into the table-base register, picks a direction and sets START. The engine then reads each descriptor, moves the buffer it describes one 32-bit beat at a time, and goes on to the next descriptor until it has finished one whose address word carries the end marker. If descriptor mode is off, START moves a single block whose address and byte count software wrote directly into two registers.

The memory side is a single-outstanding request port. A request is held with a stable address until `mem_ack` is seen, and it counts as done only in that cycle. The device side is a pair of valid/ready streams, one for each direction. Software reads the status register to learn whether the engine is busy and how the last transfer ended. Software can abort a transfer with STOP, and can hold the engine inert with the reset bit.

Register addresses on `reg_addr`: 0 control, 1 status, 2 table base, 3 block address, 4 block byte count. Registers 3 and 4 read back the live pointer and the remaining byte count.

Top module: `sg_dma_engine`

## Requirements
- R1: After `rst_n` is released, every register reads 0, status bit 0 (active) is 0, and neither `mem_req` nor `dev_tx_valid` is asserted.
- R2: The control register holds START at bit 0, STOP at bit 1, direction at bit 2 (1 = memory to device), descriptor mode at bit 3, reset at bit 7, 32-bit descriptor mode at bit 11 and mode select at bit 16. A control write with bit 0 set starts a transfer: status bit 0 and control bit 0 both read 1 on the next cycle.
- R3: A descriptor is word 0 (buffer address) at the pointer and word 1 (byte length) at pointer+4, and the next descriptor follows at pointer+8. Bit 0 of word 0 set marks the last descriptor, and the buffer address used is word 0 with bit 0 cleared. Fetch starts at the table base.
- R4: With direction 1, each buffer is read from memory at ascending word addresses and sent on `dev_tx_data` in order, ceil(length/4) beats per descriptor. Data is held stable while `dev_tx_ready` is low.
- R5: With direction 0, words taken from `dev_rx_data` are written to memory at ascending word addresses.
- R6: When the last descriptor completes, status bit 0 clears, status bit 1 (normal end) sets, and control bit 0 reads 0.
- R7: A control write with bit 1 set while active ends the transfer on the next cycle. Control bit 0 clears, status bit 6 (forced end) sets, and no further memory request or device beat is issued.
- R8: A memory response with `mem_err` set sets status bit 2 and stops the engine.
- R9: A `dev_irq` pulse sets status bit 4. A `dev_term` pulse while active sets status bit 5 and ends the transfer.
- R10: A START write while active has no effect: the current chain continues without restarting.
- R11: While control bit 7 is 1, the engine stays idle, all status bits read 0, and START is ignored in any control write that sets bit 7.
- R12: Writing 1 to status bits 1, 2, 4, 5 or 6 clears that bit only.
- R13: With control bit 3 at 0, START moves one block from the block-address register (3) for the byte count in register 4, with no descriptor fetch.
- R14: A zero-length descriptor moves no data and the chain continues. Buffer addresses increase linearly across 64 KB boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_err | input | 1 | Completion carries an error |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| dev_tx_valid | output | 1 | Beat to device valid |
| dev_tx_data | output | 32 | Beat to device |
| dev_tx_ready | input | 1 | Device accepts beat |
| dev_rx_valid | input | 1 | Beat from device valid |
| dev_rx_data | input | 32 | Beat from device |
| dev_rx_ready | output | 1 | Engine accepts beat |
| dev_irq | input | 1 | Device interrupt pulse |
| dev_term | input | 1 | Device terminates transfer |

## Verification
The bench targets the end-of-table flag in the address word. A design that took it from the length word, or kept bit 0 in the buffer address, would emit the wrong beats or finish the chain early. A restart on a second START is exposed by issuing START after the first beat has gone out: a restarting engine repeats that beat. Other targets are a short final beat, a zero-length descriptor, and an address carry past 0xFFFF. A stopped or errored engine that kept requesting memory, or a reset hold that let status bits or a START through, shows up at the ports and in the status readback.

// File: rtl/sg_dma_engine.sv
`timescale 1ns/1ps
module sg_dma_engine #(
  parameter int DW  = 32,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [DW-1:0]  mem_rdata,
  output logic           dev_tx_valid,
  output logic [DW-1:0]  dev_tx_data,
  input  logic           dev_tx_ready,
  input  logic           dev_rx_valid,
  input  logic [DW-1:0]  dev_rx_data,
  output logic           dev_rx_ready,
  input  logic           dev_irq,
  input  logic           dev_term
);
  localparam int BB = DW / 8;
  localparam logic [RAW-1:0] A_CTRL  = RAW'(0);
  localparam logic [RAW-1:0] A_STAT  = RAW'(1);
  localparam logic [RAW-1:0] A_TBASE = RAW'(2);
  localparam logic [RAW-1:0] A_BADDR = RAW'(3);
  localparam logic [RAW-1:0] A_BCNT  = RAW'(4);

  typedef enum logic [2:0] {S_IDLE, S_DESC0, S_DESC1, S_BLK, S_MRD, S_TX, S_RX, S_MWR} st_t;
  st_t st;

  logic start_q, dir_q, dese_q, rstb_q, dta_q, ism_q, xdir_q, last_q;
  logic nend_q, err_q, devint_q, devtrm_q, dnend_q;
  logic [DW-1:0] tbase_q, dptr_q, baddr_q, bcnt_q, beat_q, step;
  logic act, ctrl_wr, stat_wr, hold_rst, stop_req, start_req;
  logic mem_hit, mem_bad, term_hit, kill, fin;

  assign act       = (st != S_IDLE);
  assign ctrl_wr   = reg_we && (reg_addr == A_CTRL);
  assign stat_wr   = reg_we && (reg_addr == A_STAT);
  assign hold_rst  = rstb_q | (ctrl_wr & reg_wdata[7]);
  assign stop_req  = ctrl_wr & reg_wdata[1] & act;
  assign start_req = ctrl_wr & reg_wdata[0] & ~reg_wdata[1] & ~reg_wdata[7] & ~act;
  assign mem_hit   = mem_req & mem_ack;
  assign mem_bad   = mem_hit & mem_err;
  assign term_hit  = act & dev_term;
  assign kill      = stop_req | hold_rst | term_hit | mem_bad;
  assign fin       = (st == S_BLK) && (bcnt_q == '0) && last_q;
  assign step      = (bcnt_q < DW'(BB)) ? bcnt_q : DW'(BB);

  assign mem_req      = (st == S_DESC0) || (st == S_DESC1) || (st == S_MRD) || (st == S_MWR);
  assign mem_we       = (st == S_MWR);
  assign mem_addr     = (st == S_DESC0) ? dptr_q :
                        (st == S_DESC1) ? dptr_q + DW'(BB) : baddr_q;
  assign mem_wdata    = beat_q;
  assign dev_tx_valid = (st == S_TX);
  assign dev_tx_data  = beat_q;
  assign dev_rx_ready = (st == S_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      start_q <= 1'b0; dir_q <= 1'b0; dese_q <= 1'b0; rstb_q <= 1'b0;
      dta_q <= 1'b0; ism_q <= 1'b0; xdir_q <= 1'b0; last_q <= 1'b0;
      tbase_q <= '0; dptr_q <= '0; baddr_q <= '0; bcnt_q <= '0; beat_q <= '0;
    end else begin
      if (ctrl_wr) begin
        rstb_q <= reg_wdata[7];
        dir_q  <= reg_wdata[2];
        dese_q <= reg_wdata[3];
        dta_q  <= reg_wdata[11];
        ism_q  <= reg_wdata[16];
      end
      if (reg_we && !act) begin
        if (reg_addr == A_TBASE) tbase_q <= reg_wdata;
        if (reg_addr == A_BADDR) baddr_q <= reg_wdata;
        if (reg_addr == A_BCNT)  bcnt_q  <= reg_wdata;
      end
      if (kill) begin
        st      <= S_IDLE;
        start_q <= 1'b0;
      end else if (start_req) begin
        start_q <= 1'b1;
        xdir_q  <= reg_wdata[2];
        if (reg_wdata[3]) begin
          dptr_q <= tbase_q;
          st     <= S_DESC0;
        end else begin
          last_q <= 1'b1;
          st     <= S_BLK;
        end
      end else begin
        case (st)
          S_DESC0: if (mem_hit) begin
            baddr_q <= {mem_rdata[DW-1:1], 1'b0};
            last_q  <= mem_rdata[0];
            st      <= S_DESC1;
          end
          S_DESC1: if (mem_hit) begin
            bcnt_q <= mem_rdata;
            dptr_q <= dptr_q + DW'(2 * BB);
            st     <= S_BLK;
          end
          S_BLK: begin
            if (bcnt_q == '0) begin
              if (last_q) begin
                st      <= S_IDLE;
                start_q <= 1'b0;
              end else begin
                st <= S_DESC0;
              end
            end else begin
              st <= xdir_q ? S_MRD : S_RX;
            end
          end
          S_MRD: if (mem_hit) begin
            beat_q <= mem_rdata;
            st     <= S_TX;
          end
          S_TX: if (dev_tx_ready) begin
            baddr_q <= baddr_q + DW'(BB);
            bcnt_q  <= bcnt_q - step;
            st      <= S_BLK;
          end
          S_RX: if (dev_rx_valid) begin
            beat_q <= dev_rx_data;
            st     <= S_MWR;
          end
          S_MWR: if (mem_hit) begin
            baddr_q <= baddr_q + DW'(BB);
            bcnt_q  <= bcnt_q - step;
            st      <= S_BLK;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nend_q <= 1'b0; err_q <= 1'b0; devint_q <= 1'b0; devtrm_q <= 1'b0; dnend_q <= 1'b0;
    end else if (hold_rst) begin
      nend_q <= 1'b0; err_q <= 1'b0; devint_q <= 1'b0; devtrm_q <= 1'b0; dnend_q <= 1'b0;
    end else begin
      nend_q   <= (nend_q   & ~(stat_wr & reg_wdata[1])) | (fin & ~kill);
      err_q    <= (err_q    & ~(stat_wr & reg_wdata[2])) | mem_bad;
      devint_q <= (devint_q & ~(stat_wr & reg_wdata[4])) | dev_irq;
      devtrm_q <= (devtrm_q & ~(stat_wr & reg_wdata[5])) | term_hit;
      dnend_q  <= (dnend_q  & ~(stat_wr & reg_wdata[6])) | stop_req;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'({ism_q, 4'd0, dta_q, 3'd0, rstb_q, 3'd0, dese_q, dir_q, 1'b0, start_q});
      A_STAT:  reg_rdata = DW'({dnend_q, devtrm_q, devint_q, 1'b0, err_q, nend_q, act});
      A_TBASE: reg_rdata = tbase_q;
      A_BADDR: reg_rdata = baddr_q;
      A_BCNT:  reg_rdata = bcnt_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_ACT_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> start_q); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !kill |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready && !kill |=> dev_tx_valid && $stable(dev_tx_data)); // R4
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !hold_rst |=> !act && dnend_q && !mem_req); // R7
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_bad && !hold_rst |=> !act && err_q); // R8
  AST_RSTBIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rstb_q |-> !act && !nend_q && !err_q && !devint_q && !devtrm_q && !dnend_q); // R11
endmodule

// File: tb/tb_sg_dma_engine.sv
`timescale 1ns/1ps
module tb_sg_dma_engine;
  logic clk, rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready, dev_irq, dev_term;
  logic [31:0] dev_tx_data, dev_rx_data;

  sg_dma_engine dut (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] mem_w [0:255];
  logic [31:0] tx_log [0:63];
  logic [31:0] rx_src [0:7];
  int tx_n = 0, tx_mode = 0, rx_idx = 0, rx_n = 0;
  logic rx_hs = 0, mem_slow = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0] ready_ph = 0;

  initial begin clk = 0; forever #2.5 clk = ~clk; end

  initial begin
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !(mem_slow && mem_ack)) begin
        mem_ack = 1;
        mem_err = (mem_addr == err_addr);
        if (mem_we) begin
          if (!mem_err) mem_w[mem_addr[9:2]] = mem_wdata;
          mem_rdata = 0;
        end else mem_rdata = mem_w[mem_addr[9:2]];
      end else begin
        mem_ack = 0; mem_err = 0;
      end
    end
  end

  initial begin
    dev_tx_ready = 0;
    forever begin
      @(negedge clk);
      ready_ph = ready_ph + 1;
      dev_tx_ready = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? ready_ph[0] : 1'b0;
      #1;
      if (dev_tx_valid && dev_tx_ready) begin
        tx_log[tx_n[5:0]] = dev_tx_data;
        tx_n++;
      end
    end
  end

  initial begin
    dev_rx_valid = 0; dev_rx_data = 0;
    forever begin
      @(negedge clk);
      if (rx_hs) rx_idx++;
      dev_rx_valid = (rx_idx < rx_n);
      dev_rx_data = rx_src[rx_idx[2:0]];
      #1;
      rx_hs = dev_rx_valid && dev_rx_ready;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    chk(req, "transfer did not end", 32'd1, 32'd0);
  endtask

  task automatic pulse_irq();
    @(negedge clk); dev_irq = 1;
    @(negedge clk); dev_irq = 0;
  endtask

  task automatic pulse_term();
    @(negedge clk); dev_term = 1;
    @(negedge clk); dev_term = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1", "ctrl after reset", v, 32'h0);
    rd(3'd1, v); chk("R1", "status after reset", v, 32'h0);
    rd(3'd2, v); chk("R1", "table base after reset", v, 32'h0);
    chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "tx_valid after reset", {31'd0, dev_tx_valid}, 32'd0);
  endtask

  task automatic t_chain_write();
    logic [31:0] v;
    mem_w[8'h40] = 32'h200; mem_w[8'h41] = 32'd8;
    mem_w[8'h42] = 32'h301; mem_w[8'h43] = 32'd6;
    mem_w[8'h80] = 32'hA000_0000; mem_w[8'h81] = 32'hA000_0001;
    mem_w[8'hC0] = 32'hB000_0000; mem_w[8'hC1] = 32'hB000_0001;
    tx_n = 0; tx_mode = 1;
    wr(3'd2, 32'h100);
    wr(3'd0, 32'hD);
    rd(3'd1, v); chk("R2", "active after start", v & 32'h1, 32'h1);
    rd(3'd0, v); chk("R2", "start bit reads 1", v & 32'h1, 32'h1);
    wait_idle("R6");
    chk("R4", "beat count", tx_n, 4);
    chk("R4", "beat0", tx_log[0], 32'hA000_0000);
    chk("R4", "beat1", tx_log[1], 32'hA000_0001);
    chk("R3", "beat2 from last desc", tx_log[2], 32'hB000_0000);
    chk("R3", "beat3 short tail", tx_log[3], 32'hB000_0001);
    rd(3'd1, v); chk("R6", "status normal end", v, 32'h2);
    rd(3'd0, v); chk("R6", "start cleared", v, 32'hC);
    rd(3'd3, v); chk("R3", "pointer end, bit0 cleared", v, 32'h308);
    rd(3'd4, v); chk("R4", "remaining bytes", v, 32'h0);
    tx_mode = 0;
  endtask

  task automatic t_chain_read();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    mem_w[8'h50] = 32'h3D1; mem_w[8'h51] = 32'd12;
    rx_src[0] = 32'h1111_0000; rx_src[1] = 32'h2222_0000; rx_src[2] = 32'h3333_0000;
    rx_idx = 0; rx_n = 3; mem_slow = 1;
    wr(3'd2, 32'h140);
    wr(3'd0, 32'h9);
    wait_idle("R5");
    chk("R5", "mem word0", mem_w[8'hF4], 32'h1111_0000);
    chk("R5", "mem word1", mem_w[8'hF5], 32'h2222_0000);
    chk("R5", "mem word2", mem_w[8'hF6], 32'h3333_0000);
    rd(3'd1, v); chk("R5", "status normal end", v, 32'h2);
    mem_slow = 0; rx_n = 0;
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    mem_w[8'h90] = 32'hC000_0000; mem_w[8'h91] = 32'hC000_0001;
    mem_w[8'h92] = 32'hC000_0002; mem_w[8'h93] = 32'hC000_0003;
    tx_n = 0;
    wr(3'd3, 32'h240); wr(3'd4, 32'd8);
    wr(3'd0, 32'h5);
    wait_idle("R13");
    chk("R13", "direct beat count", tx_n, 2);
    chk("R13", "direct beat0", tx_log[0], 32'hC000_0000);
    chk("R13", "direct beat1", tx_log[1], 32'hC000_0001);
    rd(3'd1, v); chk("R13", "direct status", v, 32'h2);
  endtask

  task automatic t_zero_and_cross();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    mem_w[8'h60] = 32'h280; mem_w[8'h61] = 32'd0;
    mem_w[8'h62] = 32'h2C1; mem_w[8'h63] = 32'd4;
    mem_w[8'hB0] = 32'hD000_0000;
    tx_n = 0;
    wr(3'd2, 32'h180);
    wr(3'd0, 32'hD);
    wait_idle("R14");
    chk("R14", "zero-length skipped, beats", tx_n, 1);
    chk("R14", "beat after zero-length", tx_log[0], 32'hD000_0000);
    mem_w[8'hFE] = 32'hE000_0000; mem_w[8'hFF] = 32'hE000_0001;
    mem_w[8'h00] = 32'hE000_0002; mem_w[8'h01] = 32'hE000_0003;
    tx_n = 0;
    wr(3'd1, 32'h7F);
    wr(3'd3, 32'h0000_FFF8); wr(3'd4, 32'd16);
    wr(3'd0, 32'h5);
    wait_idle("R14");
    chk("R14", "64K crossing beats", tx_n, 4);
    chk("R14", "beat past boundary", tx_log[2], 32'hE000_0002);
    rd(3'd3, v); chk("R14", "pointer past 64K", v, 32'h0001_0008);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int busy;
    wr(3'd1, 32'h7F);
    tx_mode = 2; tx_n = 0;
    wr(3'd3, 32'h240); wr(3'd4, 32'd64);
    wr(3'd0, 32'h5);
    repeat (3) @(negedge clk);
    rd(3'd1, v); chk("R7", "active before stop", v & 32'h1, 32'h1);
    wr(3'd0, 32'h6);
    rd(3'd1, v); chk("R7", "status after stop", v, 32'h40);
    rd(3'd0, v); chk("R7", "start bit after stop", v & 32'h1, 32'h0);
    busy = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (mem_req || dev_tx_valid) busy++;
    end
    chk("R7", "activity after stop", busy, 0);
    tx_mode = 0;
  endtask

  task automatic t_restart_ignored();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    tx_n = 0; tx_mode = 1;
    wr(3'd2, 32'h100);
    wr(3'd0, 32'hD);
    for (int i = 0; i < 200 && tx_n < 1; i++) @(negedge clk);
    wr(3'd0, 32'hD);
    rd(3'd1, v); chk("R10", "still active after second start", v & 32'h1, 32'h1);
    wait_idle("R10");
    chk("R10", "no restart, beat count", tx_n, 4);
    chk("R10", "second beat not repeated", tx_log[1], 32'hA000_0001);
    tx_mode = 0;
  endtask

  task automatic t_mem_error();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    err_addr = 32'h248; tx_n = 0;
    wr(3'd3, 32'h240); wr(3'd4, 32'd16);
    wr(3'd0, 32'h5);
    wait_idle("R8");
    rd(3'd1, v); chk("R8", "status after error", v, 32'h4);
    chk("R8", "beats before error", tx_n, 2);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_device_events();
    logic [31:0] v;
    wr(3'd1, 32'h7F);
    pulse_irq();
    rd(3'd1, v); chk("R9", "device interrupt flag", v, 32'h10);
    tx_mode = 2;
    wr(3'd3, 32'h240); wr(3'd4, 32'd16);
    wr(3'd0, 32'h5);
    repeat (3) @(negedge clk);
    pulse_term();
    rd(3'd1, v); chk("R9", "device terminate ends transfer", v, 32'h30);
    wr(3'd1, 32'h10);
    rd(3'd1, v); chk("R12", "clear one flag only", v, 32'h20);
    wr(3'd1, 32'h20);
    rd(3'd1, v); chk("R12", "clear remaining flag", v, 32'h0);
    tx_mode = 0;
  endtask

  task automatic t_reset_bit();
    logic [31:0] v;
    int busy;
    pulse_irq();
    wr(3'd0, 32'h80);
    rd(3'd1, v); chk("R11", "status cleared by reset bit", v, 32'h0);
    wr(3'd0, 32'h85);
    rd(3'd0, v); chk("R11", "start ignored under reset", v, 32'h84);
    busy = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      if (mem_req || dev_tx_valid) busy++;
    end
    chk("R11", "no activity under reset", busy, 0);
    pulse_irq();
    rd(3'd1, v); chk("R11", "flags held clear", v, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; dev_irq = 0; dev_term = 0;
    for (int i = 0; i < 256; i++) mem_w[i] = 32'h0;
    for (int i = 0; i < 8; i++) rx_src[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_chain_write();
    t_chain_read();
    t_direct();
    t_zero_and_cross();
    t_stop();
    t_restart_ignored();
    t_mem_error();
    t_device_events();
    t_reset_bit();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule